// File: doc/BRIEF.md
# Dual 8-bit GPIO Port Controller with Edge Interrupts

This block gives a small processor two 8-bit general-purpose I/O ports through a byte-wide I/O bus. The bus has an address, write data, a write strobe, a read strobe and combinational read data. Each pin has three settings: an output data bit, a combined pull-up and edge-polarity bit, and a 4-bit sink-current code. From these the block drives the pad control lines: sink enable with its current code, pull-up enable, or high impedance.

Pin levels pass through a two-flop synchroniser. A read of a port's data address returns these sensed levels, not the written value. An edge detector watches the synchronised levels for the transition that each pin's polarity bit selects. Any such edge on a pin whose interrupt enable is set raises a sticky interrupt request, and the request stays up until software writes the clear address.

To use a pin as an input, software writes 1 to its data bit. It then writes its pull-up/polarity bit to pick both the idle level and the interrupt edge.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset the data bits of both ports are 1, the pull-up/polarity bits are 0, all sink codes are 0, all interrupt enables are 0 and `irq` is 0. So every pin starts with its pull-up engaged and no pin sinks current.
- R2: Each pin asserts exactly one of `sink_en`, `pullup_en` and `hiz`. Data bit 0 gives sink, whatever the pull-up bit is. Data bit 1 with pull-up bit 0 gives pull-up. Data bit 1 with pull-up bit 1 gives high impedance.
- R3: Reading address 0x00 (port 0) or 0x01 (port 1) returns the pin levels of that port, bit n for pin n. A change on `pin_in` shows in the readback after two rising clock edges.
- R4: The pull-up/polarity registers at 0x08 (port 0) and 0x09 (port 1) are write-only, and so are the sink registers. Reads of them, and of any address outside the map, return 0x00. Writes to unmapped addresses change no output.
- R5: The sink register of port p, pin n sits at address 0x30 + 8p + n. It keeps only write-data bits 3:0, and it drives `sink_code` bits [4k+3:4k], where k = 8p + n. Code 0000 is the weakest level and 1111 the strongest.
- R6: A pull-up/polarity bit of 1 selects a low-to-high transition as the interrupt edge, and 0 selects high-to-low. The opposite transition does not raise `irq`.
- R7: A selected edge on an enabled pin sets `irq` three rising edges after the `pin_in` change. `irq` then stays set until a write of any value to address 0x18.
- R8: The interrupt enable registers at 0x10 (port 0) and 0x11 (port 1) hold one bit per pin and read back as written. An edge on a pin whose enable bit is 0 does not set `irq`.
- R9: If a clear write and a qualifying edge fall on the same clock edge, `irq` ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Bus address for reads and writes |
| wr_data | input | 8 | Bus write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; read data is valid while it is high |
| rd_data | output | 8 | Read data, 0x00 when `rd_en` is low |
| pin_in | input | 16 | Pad input levels, port 1 in bits 15:8 |
| sink_en | output | 16 | Per-pin current-sink enable |
| sink_code | output | 64 | Per-pin 4-bit sink-current code |
| pullup_en | output | 16 | Per-pin pull-up resistor enable |
| hiz | output | 16 | Per-pin high-impedance indication |
| irq | output | 1 | Sticky interrupt request |

## Verification
The hardest case to reach from the ports is the race in R9. A qualifying edge must be detected inside the block in the same cycle that a clear write is taken. The bench counts the two synchroniser stages and changes a pin level at a falling edge. It then starts the clear write exactly two falling edges later, so that the clear and the edge are taken on the same clock edge. The polarity and enable cases start from a cleared request, so a missed or spurious edge shows up directly on `irq`.

// File: rtl/gpio_pkg.sv
// Shared constants and types for the GPIO port controller.
// Assumes a byte-wide bus with an 8-bit address space.
package gpio_pkg;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_DATA = 8'h00;  // + port index
    localparam logic [ADDR_W-1:0] A_PULL = 8'h08;  // + port index
    localparam logic [ADDR_W-1:0] A_IEN  = 8'h10;  // + port index
    localparam logic [ADDR_W-1:0] A_ICLR = 8'h18;
    localparam logic [ADDR_W-1:0] A_SINK = 8'h30;  // + port*PORT_W + pin

    typedef enum logic [1:0] {
        PM_SINK   = 2'd0,
        PM_PULLUP = 2'd1,
        PM_HIZ    = 2'd2
    } pin_mode_e;
endpackage

// File: rtl/gpio_port_regs.sv
// Register set of one port: data, pull-up/polarity, interrupt enable and
// per-pin sink codes, plus this port's share of the read mux.
// Assumes PORT_W <= DATA_W and CODE_W <= DATA_W.
module gpio_port_regs
    import gpio_pkg::*;
#(
    parameter int PORT_IDX = 0,
    parameter int PORT_W   = 8,
    parameter int CODE_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [PORT_W-1:0]        pins_sync,
    output logic [PORT_W-1:0]        data_q,
    output logic [PORT_W-1:0]        pull_q,
    output logic [PORT_W-1:0]        ien_q,
    output logic [PORT_W*CODE_W-1:0] sink_q,
    output logic [DATA_W-1:0]        rd_val
);
    localparam logic [ADDR_W-1:0] MY_DATA  = A_DATA + ADDR_W'(PORT_IDX);
    localparam logic [ADDR_W-1:0] MY_PULL  = A_PULL + ADDR_W'(PORT_IDX);
    localparam logic [ADDR_W-1:0] MY_IEN   = A_IEN  + ADDR_W'(PORT_IDX);
    localparam logic [ADDR_W-1:0] MY_SINK0 = A_SINK + ADDR_W'(PORT_IDX * PORT_W);

    // Port-wide registers: data, pull-up/polarity and interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '1;
            pull_q <= '0;
            ien_q  <= '0;
        end else if (wr_en) begin
            if (addr == MY_DATA) data_q <= wr_data[PORT_W-1:0];
            if (addr == MY_PULL) pull_q <= wr_data[PORT_W-1:0];
            if (addr == MY_IEN)  ien_q  <= wr_data[PORT_W-1:0];
        end
    end

    // Per-pin sink codes; only the low CODE_W write bits are kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sink_q <= '0;
        end else if (wr_en) begin
            for (int n = 0; n < PORT_W; n++) begin
                if (addr == MY_SINK0 + ADDR_W'(n))
                    sink_q[n*CODE_W +: CODE_W] <= wr_data[CODE_W-1:0];
            end
        end
    end

    // Readable registers of this port; write-only ones return zero.
    always_comb begin
        rd_val = '0;
        if (addr == MY_DATA)     rd_val = DATA_W'(pins_sync);
        else if (addr == MY_IEN) rd_val = DATA_W'(ien_q);
    end
endmodule

// File: rtl/gpio_pin_drive.sv
// Pad control encoding for one pin from its data and pull-up bits.
// A low data bit always sinks; the three outputs are mutually exclusive.
module gpio_pin_drive
    import gpio_pkg::*;
(
    input  logic data_bit,
    input  logic pull_bit,
    output logic sink_en,
    output logic pullup_en,
    output logic hiz
);
    pin_mode_e mode;

    // Pick the drive mode from the two configuration bits.
    always_comb begin
        if (!data_bit)     mode = PM_SINK;
        else if (pull_bit) mode = PM_HIZ;
        else               mode = PM_PULLUP;
    end

    // Decode the mode onto the pad control lines.
    always_comb begin
        sink_en   = (mode == PM_SINK);
        pullup_en = (mode == PM_PULLUP);
        hiz       = (mode == PM_HIZ);
    end
endmodule

// File: rtl/gpio_in_edge.sv
// Input synchroniser chain and polarity-selected edge detector.
// Assumes pins idle high; all stages reset to 1 so reset makes no edge.
module gpio_in_edge #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_async,
    input  logic [W-1:0] polarity,   // 1: rising, 0: falling
    output logic [W-1:0] pins_sync,
    output logic [W-1:0] edges
);
    logic [W-1:0] chain [STAGES];
    logic [W-1:0] prev_q;

    // Shift the pad levels through the synchroniser stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '1;
        end else begin
            chain[0] <= pins_async;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign pins_sync = chain[STAGES-1];

    // Keep the previous synchronised level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= pins_sync;
    end

    // Select rising or falling transitions per pin.
    always_comb begin
        edges = (polarity & pins_sync & ~prev_q) | (~polarity & ~pins_sync & prev_q);
    end
endmodule

// File: rtl/gpio_edge_ctrl.sv
// Top of the two-port GPIO controller: register banks per port, pad drive
// per pin, input synchroniser, and the sticky masked interrupt request.
// Assumes single-cycle bus strobes and combinational read data.
module gpio_edge_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_PORTS   = 2,
    parameter int PORT_W      = 8,
    parameter int CODE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [ADDR_W-1:0]                      addr,
    input  logic [DATA_W-1:0]                      wr_data,
    input  logic                                   wr_en,
    input  logic                                   rd_en,
    output logic [DATA_W-1:0]                      rd_data,
    input  logic [NUM_PORTS*PORT_W-1:0]            pin_in,
    output logic [NUM_PORTS*PORT_W-1:0]            sink_en,
    output logic [NUM_PORTS*PORT_W*CODE_W-1:0]     sink_code,
    output logic [NUM_PORTS*PORT_W-1:0]            pullup_en,
    output logic [NUM_PORTS*PORT_W-1:0]            hiz,
    output logic                                   irq
);
    localparam int NPINS = NUM_PORTS * PORT_W;

    logic [NPINS-1:0]  data_all, pull_all, ien_all;
    logic [NPINS-1:0]  pins_sync, edges, edge_hit;
    logic [DATA_W-1:0] rd_vals [NUM_PORTS];
    logic              irq_q;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        gpio_port_regs #(
            .PORT_IDX (p),
            .PORT_W   (PORT_W),
            .CODE_W   (CODE_W)
        ) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_en),
            .addr      (addr),
            .wr_data   (wr_data),
            .pins_sync (pins_sync[p*PORT_W +: PORT_W]),
            .data_q    (data_all[p*PORT_W +: PORT_W]),
            .pull_q    (pull_all[p*PORT_W +: PORT_W]),
            .ien_q     (ien_all[p*PORT_W +: PORT_W]),
            .sink_q    (sink_code[p*PORT_W*CODE_W +: PORT_W*CODE_W]),
            .rd_val    (rd_vals[p])
        );
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_pin_drive u_drive (
            .data_bit  (data_all[i]),
            .pull_bit  (pull_all[i]),
            .sink_en   (sink_en[i]),
            .pullup_en (pullup_en[i]),
            .hiz       (hiz[i])
        );
    end

    gpio_in_edge #(
        .W      (NPINS),
        .STAGES (SYNC_STAGES)
    ) u_in (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins_async (pin_in),
        .polarity   (pull_all),
        .pins_sync  (pins_sync),
        .edges      (edges)
    );

    assign edge_hit = edges & ien_all;

    // Sticky request: a new edge beats a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                               irq_q <= 1'b0;
        else if (|edge_hit)                       irq_q <= 1'b1;
        else if (wr_en && addr == A_ICLR)         irq_q <= 1'b0;
    end

    assign irq = irq_q;

    // Merge port read values; idle bus reads as zero.
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            for (int p = 0; p < NUM_PORTS; p++) rd_data = rd_data | rd_vals[p];
        end
    end
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
// Assertion checker for gpio_edge_ctrl, attached by bind below.
module gpio_edge_ctrl_chk
    import gpio_pkg::*;
#(
    parameter int NPINS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic [NPINS-1:0]  sink_en,
    input logic [NPINS-1:0]  pullup_en,
    input logic [NPINS-1:0]  hiz,
    input logic [NPINS-1:0]  edge_hit,
    input logic              irq
);
    for (genvar i = 0; i < NPINS; i++) begin : g_mode
        // R2: one pad mode per pin
        a_r2_one_mode: assert property (@(posedge clk) disable iff (!rst_n)
            $countones({sink_en[i], pullup_en[i], hiz[i]}) == 1);
    end

    // R2: writing a low data bit makes the pin sink on the next cycle
    a_r2_low_sinks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DATA && !wr_data[0]) |=> sink_en[0]);

    // R4: write-only and pull-up addresses read as zero
    a_r4_wo_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == A_PULL || addr == A_PULL + 8'd1 || addr[7:4] == 4'h3))
        |-> rd_data == '0);

    // R7: request holds until a clear write
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(wr_en && addr == A_ICLR)) |=> irq);

    // R7: a clear with no edge drops the request
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_ICLR && !(|edge_hit)) |=> !irq);

    // R9: any qualified edge leaves the request set, clear or not
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_hit) |=> irq);
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wr_data   (wr_data),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .sink_en   (sink_en),
    .pullup_en (pullup_en),
    .hiz       (hiz),
    .edge_hit  (edge_hit),
    .irq       (irq)
);

// File: tb/gpio_edge_ctrl_bench.sv
module gpio_edge_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  addr;
    logic [7:0]  wr_data;
    logic        wr_en;
    logic        rd_en;
    logic [7:0]  rd_data;
    logic [15:0] pin_in;
    logic [15:0] sink_en, pullup_en, hiz;
    logic [63:0] sink_code;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;  // 250 MHz

    gpio_edge_ctrl u_gpio_edge_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .wr_data   (wr_data),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .pin_in    (pin_in),
        .sink_en   (sink_en),
        .sink_code (sink_code),
        .pullup_en (pullup_en),
        .hiz       (hiz),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; one-cycle write strobe.
    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = '0;
        pin_in = 16'hFFFF;
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(1);
        check("R1 pullup_en", 64'(pullup_en), 64'hFFFF);
        check("R1 sink_en", 64'(sink_en), 64'h0);
        check("R1 sink_code", sink_code, 64'h0);
        check("R1 irq", 64'(irq), 64'h0);
        bus_read(8'h10, d);
        check("R1 ien port0", 64'(d), 64'h0);
    endtask

    task automatic t_drive_modes;
        bus_write(8'h00, 8'hF0);
        bus_write(8'h08, 8'hCC);
        check("R2 sink", 64'(sink_en[7:0]), 64'h0F);
        check("R2 pullup", 64'(pullup_en[7:0]), 64'h30);
        check("R2 hiz", 64'(hiz[7:0]), 64'hC0);
        bus_write(8'h00, 8'hFF);
        bus_write(8'h08, 8'h00);
    endtask

    task automatic t_readback;
        logic [7:0] d;
        pin_in[15:8] = 8'hA5;
        wait_neg(1);
        bus_read(8'h01, d);
        check("R3 after one edge", 64'(d), 64'hFF);
        wait_neg(1);
        bus_read(8'h01, d);
        check("R3 after two edges", 64'(d), 64'hA5);
        pin_in[15:8] = 8'hFF;
        wait_neg(3);
    endtask

    task automatic t_write_only;
        logic [7:0] d;
        logic [47:0] snap;
        bus_write(8'h09, 8'hFF);
        check("R4 pull port1 drives hiz", 64'(hiz[15:8]), 64'hFF);
        bus_read(8'h09, d);
        check("R4 read 0x09", 64'(d), 64'h0);
        bus_read(8'h08, d);
        check("R4 read 0x08", 64'(d), 64'h0);
        bus_write(8'h09, 8'h00);
        snap = {sink_en, pullup_en, hiz};
        bus_write(8'h20, 8'h00);
        bus_write(8'h05, 8'h00);
        check("R4 unmapped write", 64'({sink_en, pullup_en, hiz}), 64'(snap));
        bus_read(8'h20, d);
        check("R4 unmapped read", 64'(d), 64'h0);
    endtask

    task automatic t_sink_codes;
        logic [7:0] d;
        bus_write(8'h3A, 8'hF7);
        bus_write(8'h30, 8'h0B);
        check("R5 codes", sink_code, 64'h0000_0700_0000_000B);
        bus_read(8'h3A, d);
        check("R5 read sink", 64'(d), 64'h0);
    endtask

    task automatic t_polarity;
        bus_write(8'h10, 8'h01);
        bus_write(8'h08, 8'h01);     // rising
        bus_write(8'h18, 8'h00);
        pin_in[0] = 1'b0;
        wait_neg(3);
        check("R6 falling ignored", 64'(irq), 64'h0);
        pin_in[0] = 1'b1;
        wait_neg(2);
        check("R7 not yet after two edges", 64'(irq), 64'h0);
        wait_neg(1);
        check("R6 rising sets", 64'(irq), 64'h1);
        wait_neg(4);
        check("R7 sticky", 64'(irq), 64'h1);
        bus_write(8'h18, 8'h5A);
        check("R7 clear", 64'(irq), 64'h0);
        bus_write(8'h08, 8'h00);     // falling
        pin_in[0] = 1'b0;
        wait_neg(3);
        check("R6 falling sets", 64'(irq), 64'h1);
        bus_write(8'h18, 8'h00);
        pin_in[0] = 1'b1;
        wait_neg(3);
        check("R6 rising ignored", 64'(irq), 64'h0);
    endtask

    task automatic t_enable_mask;
        logic [7:0] d;
        bus_write(8'h11, 8'h00);
        bus_write(8'h09, 8'h00);
        bus_write(8'h18, 8'h00);
        pin_in[8] = 1'b0;
        wait_neg(3);
        check("R8 masked edge", 64'(irq), 64'h0);
        pin_in[8] = 1'b1;
        wait_neg(3);
        bus_write(8'h11, 8'h01);
        bus_read(8'h11, d);
        check("R8 enable readback", 64'(d), 64'h01);
        pin_in[8] = 1'b0;
        wait_neg(3);
        check("R8 enabled edge", 64'(irq), 64'h1);
        bus_write(8'h18, 8'h00);
        pin_in[8] = 1'b1;
        wait_neg(3);
    endtask

    task automatic t_clear_race;
        bus_write(8'h18, 8'h00);
        check("R9 start clear", 64'(irq), 64'h0);
        pin_in[0] = 1'b0;            // falling, port0 pin0 enabled
        wait_neg(2);
        bus_write(8'h18, 8'h00);     // taken with the detected edge
        check("R9 set wins", 64'(irq), 64'h1);
        bus_write(8'h18, 8'h00);
        check("R9 later clear", 64'(irq), 64'h0);
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(4 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_drive_modes();
        t_readback();
        t_write_only();
        t_sink_codes();
        t_polarity();
        t_enable_mask();
        t_clear_race();
        summary();
        $finish;
    end
endmodule